// File: doc/BRIEF.md
# Bit-Matrix Multiply-Accumulate Unit

This block multiplies square bit matrices and folds the product into a seed matrix. Two reduction modes are offered. In the Boolean mode the partial products (AND of a row bit of A and a column bit of B) are merged with OR. In the GF(2) mode they are merged with XOR. Every result bit starts from the corresponding bit of the accumulator operand C.

Each wide operand word packs two independent 16x16 matrices, one per 256-bit lane, and both lanes are worked on in parallel. A caller presents A, B, C and the mode bit and pulses `start`. The unit latches everything, produces one result row per clock in every lane, and raises `done` for one cycle when the whole word is ready.

Top module: `bmm_unit`

## Requirements
- R1: Within a lane, matrix element (row i, column j) is bit 16*i+j; lane 0 occupies bits [255:0] and lane 1 bits [511:256].
- R2: With mode = 0, result bit (i,j) equals C(i,j) OR the OR over k of (A(i,k) AND B(k,j)).
- R3: With mode = 1, result bit (i,j) equals C(i,j) XOR the XOR over k of (A(i,k) AND B(k,j)).
- R4: A lane's result depends only on the same lane of A, B and C.
- R5: `start` is accepted on a rising clock edge when `busy` is low; `done` goes high exactly 16 edges after that edge, stays high for one cycle only, and the full result is valid while it is high.
- R6: `busy` is high from the acceptance edge until the edge on which `done` rises, where it drops.
- R7: A `start` that arrives while `busy` is high is ignored: the running operation, its mode and its completion time are unchanged.
- R8: Operands and mode are captured at acceptance; later changes on the input buses do not alter the result in progress.
- R9: A synchronous active-high reset clears `busy`, `done` and all result bits.
- R10: No masking: every one of the 512 result bits is rewritten by each operation, regardless of the previous result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new operation |
| mode | input | 1 | Reduction: 0 = OR, 1 = XOR |
| op_a | input | 512 | Left matrices, two lanes |
| op_b | input | 512 | Right matrices, two lanes |
| op_c | input | 512 | Accumulator seed matrices, two lanes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-ready pulse |
| result | output | 512 | Accumulated product, two lanes |

## Verification
The embedded assertions watch, on every cycle, the timing contract: `done` is a single-cycle pulse that arrives exactly 16 cycles after acceptance, never overlaps `busy`, the captured operands and mode stay frozen while busy, and reset leaves the outputs cleared. The arithmetic itself (OR and XOR reductions, the bit layout, lane independence and full overwrite of the result) can only be shown by the bench's scenarios, which compare against a loop model on all-zero, all-ones, identity and random operands, and which also drive ignored start requests and changing buses mid-run.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
    localparam int unsigned BMM_DIM   = 16;
    localparam int unsigned BMM_LANES = 2;

    typedef enum logic {
        RED_OR  = 1'b0,
        RED_XOR = 1'b1
    } red_mode_e;
endpackage

// File: rtl/bmm_row_mac.sv
module bmm_row_mac #(
    parameter int unsigned DIM = 16,
    localparam int unsigned MAT = DIM * DIM
) (
    input  logic [DIM-1:0] a_row,
    input  logic [MAT-1:0] b_mat,
    input  logic [DIM-1:0] c_row,
    input  logic           use_xor,
    output logic [DIM-1:0] r_row
);
    for (genvar j = 0; j < DIM; j++) begin : g_col
        logic [DIM-1:0] terms;
        for (genvar k = 0; k < DIM; k++) begin : g_term
            assign terms[k] = a_row[k] & b_mat[k*DIM + j];
        end
        assign r_row[j] = use_xor ? (c_row[j] ^ (^terms)) : (c_row[j] | (|terms));
    end
endmodule

// File: rtl/bmm_lane_step.sv
module bmm_lane_step #(
    parameter int unsigned DIM = 16,
    localparam int unsigned MAT   = DIM * DIM,
    localparam int unsigned IDX_W = $clog2(DIM)
) (
    input  logic [MAT-1:0]   a_lane,
    input  logic [MAT-1:0]   b_lane,
    input  logic [MAT-1:0]   c_lane,
    input  logic [IDX_W-1:0] row_idx,
    input  logic             use_xor,
    output logic [DIM-1:0]   r_row
);
    logic [DIM-1:0] a_sel;
    logic [DIM-1:0] c_sel;

    always_comb begin
        a_sel = a_lane[row_idx*DIM +: DIM];
        c_sel = c_lane[row_idx*DIM +: DIM];
    end

    bmm_row_mac #(.DIM(DIM)) u_mac (
        .a_row   (a_sel),
        .b_mat   (b_lane),
        .c_row   (c_sel),
        .use_xor (use_xor),
        .r_row   (r_row)
    );
endmodule

// File: rtl/bmm_unit.sv
module bmm_unit
    import bmm_pkg::*;
#(
    parameter int unsigned DIM   = BMM_DIM,
    parameter int unsigned LANES = BMM_LANES,
    localparam int unsigned MAT   = DIM * DIM,
    localparam int unsigned BUS   = LANES * MAT,
    localparam int unsigned IDX_W = $clog2(DIM)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           mode,
    input  logic [BUS-1:0] op_a,
    input  logic [BUS-1:0] op_b,
    input  logic [BUS-1:0] op_c,
    output logic           busy,
    output logic           done,
    output logic [BUS-1:0] result
);
    typedef struct packed {
        logic [BUS-1:0]   a;
        logic [BUS-1:0]   b;
        logic [BUS-1:0]   c;
        logic [BUS-1:0]   res;
        red_mode_e        mode;
        logic             busy;
        logic             done;
        logic [IDX_W-1:0] row;
    } state_t;

    state_t st_d, st_q;
    logic [DIM-1:0] lane_row [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        bmm_lane_step #(.DIM(DIM)) u_step (
            .a_lane  (st_q.a[l*MAT +: MAT]),
            .b_lane  (st_q.b[l*MAT +: MAT]),
            .c_lane  (st_q.c[l*MAT +: MAT]),
            .row_idx (st_q.row),
            .use_xor (st_q.mode == RED_XOR),
            .r_row   (lane_row[l])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.a    = op_a;
                st_d.b    = op_b;
                st_d.c    = op_c;
                st_d.mode = red_mode_e'(mode);
                st_d.busy = 1'b1;
                st_d.row  = '0;
            end
        end else begin
            for (int l = 0; l < LANES; l++) begin
                st_d.res[l*MAT + st_q.row*DIM +: DIM] = lane_row[l];
            end
            st_d.row = st_q.row + 1'b1;
            if (st_q.row == IDX_W'(DIM - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign result = st_q.res;

    // Checker: cycles elapsed since acceptance
    logic [IDX_W:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else     age_q <= st_q.busy ? age_q + 1'b1 : '0;
    end

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r5_done_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (age_q == (IDX_W+1)'(DIM)));
    a_r6_busy_excl_done: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    a_r6_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy || done));
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(st_q.mode) && (busy || done)));
    a_r8_operands_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(st_q.a) && $stable(st_q.b) && $stable(st_q.c)));
    a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && (result == '0)));
endmodule

// File: tb/bmm_unit_bench.sv
module bmm_unit_bench;
    localparam int DIM = 16;
    localparam int MAT = DIM * DIM;
    localparam int BUS = 2 * MAT;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic           mode = 1'b0;
    logic [BUS-1:0] op_a = '0, op_b = '0, op_c = '0;
    logic           busy, done;
    logic [BUS-1:0] result;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bmm_unit u_bmm_unit (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .busy(busy), .done(done), .result(result)
    );

    function automatic logic [BUS-1:0] model(input logic [BUS-1:0] a, b, c, input logic m);
        logic [BUS-1:0] r;
        for (int l = 0; l < 2; l++)
            for (int i = 0; i < DIM; i++)
                for (int j = 0; j < DIM; j++) begin
                    logic acc;
                    acc = c[l*MAT + DIM*i + j];
                    for (int k = 0; k < DIM; k++) begin
                        logic t;
                        t = a[l*MAT + DIM*i + k] & b[l*MAT + DIM*k + j];
                        acc = m ? (acc ^ t) : (acc | t);
                    end
                    r[l*MAT + DIM*i + j] = acc;
                end
        return r;
    endfunction

    function automatic logic [BUS-1:0] rnd();
        logic [BUS-1:0] v;
        for (int w = 0; w < BUS/32; w++) v[w*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [BUS-1:0] ident();
        logic [BUS-1:0] v = '0;
        for (int l = 0; l < 2; l++)
            for (int i = 0; i < DIM; i++) v[l*MAT + DIM*i + i] = 1'b1;
        return v;
    endfunction

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chkw(input string req, input logic [BUS-1:0] act, input logic [BUS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one operation and check timing and result (R5, R6)
    task automatic run_op(input string req, input logic [BUS-1:0] a, b, c, input logic m);
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; mode = m; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk1("R6 busy after accept", busy, 1'b1);
        for (int n = 1; n < DIM; n++) begin
            @(posedge clk); @(negedge clk);
        end
        chk1("R5 no early done", done, 1'b0);
        @(posedge clk); @(negedge clk);
        chk1("R5 done at 16", done, 1'b1);
        chk1("R6 busy drops", busy, 1'b0);
        chkw(req, result, model(a, b, c, m));
        @(posedge clk); @(negedge clk);
        chk1("R5 done one cycle", done, 1'b0);
    endtask

    task automatic t_reset();
        chk1("R9 busy after reset", busy, 1'b0);
        chk1("R9 done after reset", done, 1'b0);
        chkw("R9 result after reset", result, '0);
    endtask

    task automatic t_zero_ones();
        run_op("R2 all zero", '0, '0, '0, 1'b0);
        run_op("R2 ones", '1, '1, '0, 1'b0);
        run_op("R3 ones xor", '1, '1, '0, 1'b1);
        run_op("R3 ones xor seeded", '1, '1, '1, 1'b1);
    endtask

    task automatic t_identity();
        logic [BUS-1:0] a = rnd(), c = rnd();
        run_op("R1 identity or", a, ident(), c, 1'b0);
        chkw("R1 identity or form", result, a | c);
        run_op("R1 identity xor", a, ident(), c, 1'b1);
        chkw("R1 identity xor form", result, a ^ c);
    endtask

    task automatic t_random();
        for (int n = 0; n < 6; n++) begin
            logic [BUS-1:0] a = rnd(), b = rnd(), c = rnd();
            run_op("R2 random or", a, b, c, 1'b0);
            run_op("R3 random xor", a, b, c, 1'b1);
        end
    endtask

    task automatic t_lanes();
        logic [BUS-1:0] a = rnd(), b = rnd(), c = rnd();
        logic [BUS-1:0] a2 = a, b2 = b, c2 = c;
        a2[BUS-1:MAT] = rnd();
        b2[BUS-1:MAT] = '0;
        run_op("R4 lane pattern", a2, b2, c2, 1'b1);
        chkw("R4 lane1 equals seed", {result[BUS-1:MAT], {MAT{1'b0}}}, {c2[BUS-1:MAT], {MAT{1'b0}}});
        chkw("R4 lane0 unaffected", {{MAT{1'b0}}, result[MAT-1:0]}, {{MAT{1'b0}}, model(a, b, c, 1'b1)} & {{MAT{1'b0}}, {MAT{1'b1}}});
    endtask

    task automatic t_overwrite();
        run_op("R10 set ones", '1, '1, '1, 1'b0);
        run_op("R10 overwrite zero", '0, '0, '0, 1'b0);
    endtask

    task automatic t_busy_start();
        logic [BUS-1:0] a = rnd(), b = rnd(), c = rnd();
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; mode = 1'b1; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int n = 1; n < DIM; n++) begin
            if (n == 5) begin
                op_a = rnd(); op_b = rnd(); op_c = rnd(); mode = 1'b0; start = 1'b1;
            end
            if (n == 9) begin
                start = 1'b0; op_a = '1; op_b = '1;
            end
            @(posedge clk); @(negedge clk);
        end
        chk1("R7 no early done", done, 1'b0);
        chk1("R7 still busy", busy, 1'b1);
        @(posedge clk); @(negedge clk);
        chk1("R7 done on time", done, 1'b1);
        chkw("R8 captured result", result, model(a, b, c, 1'b1));
        @(posedge clk); @(negedge clk);
        chk1("R7 no second run", busy, 1'b0);
    endtask

    task automatic t_reset_mid();
        run_op("R9 prefill", '1, '1, '1, 1'b0);
        @(negedge clk);
        op_a = rnd(); op_b = rnd(); start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        t_reset();
    endtask

    initial begin
        for (int n = 0; n < 150000; n++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_zero_ones();
        t_identity();
        t_random();
        t_lanes();
        t_overwrite();
        t_busy_start();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule